// File: doc/BRIEF.md
# Run-Length Sample Packer with Byte-Lane Masking

This block turns a stream of captured 32-bit samples, read from capture memory with the most recent sample first, into a byte stream for a serial readback link. Four 8-bit channel groups make up a sample. A 4-bit disable mask removes groups from the stream, so each word takes only as many bytes as there are enabled groups. The surviving groups go out lowest group first. Output uses a valid/ready byte interface.

In compressed mode, a run of equal samples goes out as one data word followed by a count word. The most significant transmitted bit of a word marks it as a count, so data words always have that bit cleared. A count of N means the sample occurred N+1 times. A run that is too long for the count field becomes several data/count pairs. A capture is started by `arm`, which latches the configuration. It ends at the sample flagged as last, or when the represented sample total reaches the configured limit. Once the output has drained, `done` goes high.

Top module: `rle_byte_packer`

## Requirements
- R1: After reset and before the first `arm`, `m_valid`, `s_ready` and `done` are all 0.
- R2: Bit g of `cfg_grp_off` (g = 0..3), when 1, removes sample bits [8g+7:8g] from every word, count words included; no byte of a disabled group is ever emitted.
- R3: Each word is sent as exactly E bytes, where E is the number of enabled groups; the enabled groups go out in ascending group order, so the lowest enabled group is the first byte.
- R4: With `cfg_rle` = 0, every accepted sample is emitted once, in acceptance order, with its enabled bytes unaltered.
- R5: With `cfg_rle` = 1, the most significant transmitted bit of every data word (bit 7 of the last byte of the word) is forced to 0.
- R6: With `cfg_rle` = 1, consecutive samples whose transmitted bits are equal form a run. A run of N+1 samples is sent as the data word and then a count word whose value is N, with its most significant transmitted bit set to 1. A run of one sample has no count word.
- R7: A run count never exceeds 2^(8E-1)-1. A longer run continues as a new data/count pair.
- R8: The number of samples represented by the output never exceeds (`cfg_quads_m1`+1)*4. A run that crosses this limit is cut short at the limit. Samples after the limit are accepted and dropped with no output.
- R9: The sample accepted with `s_last` = 1 ends the capture: any pending run is flushed, and `done` rises once the last byte has been taken.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` stay unchanged.
- R11: With all four groups disabled, no byte is emitted, and the capture still completes with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Starts a capture readout and latches the configuration; honoured when idle or done |
| cfg_grp_off | input | 4 | Group disable mask, 1 = group left out |
| cfg_rle | input | 1 | Enables run-length compression |
| cfg_quads_m1 | input | 16 | Sample limit in units of four samples, minus one |
| s_valid | input | 1 | Sample input valid |
| s_data | input | 32 | Sample input, newest first |
| s_last | input | 1 | Marks the final sample of the capture |
| s_ready | output | 1 | Sample input ready |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_ready | input | 1 | Output byte accepted |
| done | output | 1 | Capture complete and output drained |

## Verification
Some events can land on the same accepted sample: the end of a run, the end of the sample budget or `s_last`, and the count field reaching saturation. When they coincide, the block must flush the old run and then the new single sample before it stops. The bench creates these collisions deliberately. One case places a value change on the sample that reaches the limit. A single-group run of 300 equal samples forces saturation inside one capture. A short budget cuts a long run in the middle. For every case, the bench compares the whole byte stream against a model computed from the requirements. Throughout, it throttles `m_ready` with a pseudo-random pattern so that flushes overlap output back-pressure.

// File: rtl/rle_pack_pkg.sv
package rle_pack_pkg;

    typedef enum logic [2:0] {
        PK_IDLE    = 3'd0,
        PK_COLLECT = 3'd1,
        PK_SEND_S  = 3'd2,
        PK_SEND_C  = 3'd3,
        PK_DONE    = 3'd4
    } pk_state_e;

endpackage

// File: rtl/grp_compactor.sv
module grp_compactor #(
    parameter int GROUP_W = 8,
    parameter int NGRP    = 4,
    localparam int SW     = GROUP_W * NGRP,
    localparam int LW     = $clog2(NGRP + 1)
) (
    input  logic [SW-1:0]   in_word,
    input  logic [NGRP-1:0] grp_off,
    input  logic            clr_top,
    output logic [SW-1:0]   out_word,
    output logic [LW-1:0]   out_len,
    output logic [SW-1:0]   top_bit,
    output logic [SW-1:0]   run_cap
);
    logic [SW-1:0] packed_w;
    logic [SW-1:0] top_w;
    int            lanes;

    // Enabled groups are slid down towards lane zero, in ascending order.
    always_comb begin
        packed_w = '0;
        lanes    = 0;
        for (int g = 0; g < NGRP; g++) begin
            if (!grp_off[g]) begin
                packed_w[lanes*GROUP_W +: GROUP_W] = in_word[g*GROUP_W +: GROUP_W];
                lanes = lanes + 1;
            end
        end
    end

    always_comb begin
        if (lanes == 0) begin
            top_w   = '0;
            run_cap = '0;
        end else begin
            top_w   = SW'(1) << (lanes * GROUP_W - 1);
            run_cap = top_w - SW'(1);
        end
    end

    assign top_bit  = top_w;
    assign out_len  = LW'(lanes);
    assign out_word = clr_top ? (packed_w & ~top_w) : packed_w;

endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
    parameter int GROUP_W = 8,
    parameter int NGRP    = 4,
    localparam int SW     = GROUP_W * NGRP,
    localparam int LW     = $clog2(NGRP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               w_valid,
    input  logic [SW-1:0]      w_word,
    input  logic [LW-1:0]      w_len,
    output logic               w_ready,
    output logic               m_valid,
    output logic [GROUP_W-1:0] m_data,
    input  logic               m_ready
);
    typedef struct packed {
        logic [SW-1:0] sh;
        logic [LW-1:0] left;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (ser_q.left != '0 && m_ready) begin
            ser_d.sh   = ser_q.sh >> GROUP_W;
            ser_d.left = ser_q.left - LW'(1);
        end
        if (w_valid && ser_q.left == '0) begin
            ser_d.sh   = w_word;
            ser_d.left = w_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign w_ready = (ser_q.left == '0);
    assign m_valid = (ser_q.left != '0);
    assign m_data  = ser_q.sh[GROUP_W-1:0];

    // R10: a stalled byte stays put
    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R3: never more bytes queued than groups in a word
    a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ser_q.left) <= NGRP);

endmodule

// File: rtl/rle_byte_packer.sv
module rle_byte_packer #(
    parameter int GROUP_W = 8,
    parameter int NGRP    = 4,
    parameter int CNT_W   = 16,
    localparam int SW     = GROUP_W * NGRP,
    localparam int LW     = $clog2(NGRP + 1),
    localparam int TOT_W  = CNT_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [NGRP-1:0]    cfg_grp_off,
    input  logic               cfg_rle,
    input  logic [CNT_W-1:0]   cfg_quads_m1,
    input  logic               s_valid,
    input  logic [SW-1:0]      s_data,
    input  logic               s_last,
    output logic               s_ready,
    output logic               m_valid,
    output logic [GROUP_W-1:0] m_data,
    input  logic               m_ready,
    output logic               done
);
    import rle_pack_pkg::*;

    typedef struct packed {
        pk_state_e       st;
        logic [NGRP-1:0] mask;
        logic            rle;
        logic [TOT_W-1:0] limit;
        logic [TOT_W-1:0] total;
        logic [SW-1:0]   cur;
        logic            have;
        logic [SW-1:0]   nxt;
        logic            nxt_have;
        logic [SW-1:0]   run;
        logic            fin;
    } pk_t;

    pk_t pk_d, pk_q;

    logic [SW-1:0] cmp_word, cmp_top, cmp_cap;
    logic [LW-1:0] cmp_len;
    logic          w_valid, w_ready;
    logic [SW-1:0] w_word;

    grp_compactor #(.GROUP_W(GROUP_W), .NGRP(NGRP)) u_compact (
        .in_word (s_data),
        .grp_off (pk_q.mask),
        .clr_top (pk_q.rle),
        .out_word(cmp_word),
        .out_len (cmp_len),
        .top_bit (cmp_top),
        .run_cap (cmp_cap)
    );

    word_serializer #(.GROUP_W(GROUP_W), .NGRP(NGRP)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .w_valid(w_valid),
        .w_word (w_word),
        .w_len  (cmp_len),
        .w_ready(w_ready),
        .m_valid(m_valid),
        .m_data (m_data),
        .m_ready(m_ready)
    );

    logic [TOT_W-1:0] tot1;
    logic             hit_end;
    logic             pair_sent;

    always_comb begin
        pk_d      = pk_q;
        s_ready   = 1'b0;
        w_valid   = 1'b0;
        w_word    = '0;
        pair_sent = 1'b0;
        tot1      = pk_q.total + TOT_W'(1);
        hit_end   = s_last || (tot1 == pk_q.limit);

        case (pk_q.st)
            PK_IDLE, PK_DONE: begin
                s_ready = (pk_q.st == PK_DONE);
                if (arm) begin
                    pk_d.st       = PK_COLLECT;
                    pk_d.mask     = cfg_grp_off;
                    pk_d.rle      = cfg_rle;
                    pk_d.limit    = (TOT_W'(cfg_quads_m1) + TOT_W'(1)) << 2;
                    pk_d.total    = '0;
                    pk_d.have     = 1'b0;
                    pk_d.nxt_have = 1'b0;
                    pk_d.run      = '0;
                    pk_d.fin      = 1'b0;
                end
            end
            PK_COLLECT: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    pk_d.total = tot1;
                    if (!pk_q.rle || !pk_q.have) begin
                        pk_d.cur  = cmp_word;
                        pk_d.run  = '0;
                        pk_d.have = 1'b1;
                        pk_d.fin  = hit_end;
                        if (!pk_q.rle || hit_end) pk_d.st = PK_SEND_S;
                    end else if (cmp_word == pk_q.cur && pk_q.run < cmp_cap) begin
                        pk_d.run = pk_q.run + SW'(1);
                        pk_d.fin = hit_end;
                        if (hit_end) pk_d.st = PK_SEND_S;
                    end else begin
                        pk_d.nxt      = cmp_word;
                        pk_d.nxt_have = 1'b1;
                        pk_d.fin      = hit_end;
                        pk_d.st       = PK_SEND_S;
                    end
                end
            end
            PK_SEND_S: begin
                w_valid = 1'b1;
                w_word  = pk_q.cur;
                if (w_ready) begin
                    if (pk_q.run != '0) pk_d.st = PK_SEND_C;
                    else                pair_sent = 1'b1;
                end
            end
            PK_SEND_C: begin
                w_valid = 1'b1;
                w_word  = pk_q.run | cmp_top;
                if (w_ready) pair_sent = 1'b1;
            end
            default: pk_d.st = PK_IDLE;
        endcase

        if (pair_sent) begin
            pk_d.run = '0;
            if (pk_q.nxt_have) begin
                pk_d.cur      = pk_q.nxt;
                pk_d.nxt_have = 1'b0;
                pk_d.have     = 1'b1;
                pk_d.st       = pk_q.fin ? PK_SEND_S : PK_COLLECT;
            end else begin
                pk_d.have = 1'b0;
                pk_d.st   = pk_q.fin ? PK_DONE : PK_COLLECT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q    <= '0;
            pk_q.st <= PK_IDLE;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign done = (pk_q.st == PK_DONE) && w_ready;

    // R8: represented samples stay within the budget
    a_r8_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.st != PK_IDLE) |-> (pk_q.total <= pk_q.limit));

    // R7: a pending run never exceeds the count field
    a_r7_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.st != PK_IDLE) |-> (pk_q.run <= cmp_cap));

    // R6: a count word is only sent for a run longer than one
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.st == PK_SEND_C) |-> (pk_q.run != '0));

    // R3: word length handed to the serializer matches the enabled groups
    a_r3_word_len: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (int'(cmp_len) == NGRP - $countones(pk_q.mask)));

    // R9: completion implies an empty output
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !m_valid);

endmodule

// File: tb/rle_byte_packer_bench.sv
module rle_byte_packer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [3:0]  cfg_grp_off = '0;
    logic        cfg_rle = 1'b0;
    logic [15:0] cfg_quads_m1 = '0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        m_valid;
    logic [7:0]  m_data;
    logic        m_ready = 1'b0;
    logic        done;

    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] smp_q[$];
    logic [7:0]  exp_q[$];
    logic [7:0]  got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rle_byte_packer u_rle_byte_packer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_grp_off(cfg_grp_off),
        .cfg_rle(cfg_rle), .cfg_quads_m1(cfg_quads_m1), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .m_valid(m_valid),
        .m_data(m_data), .m_ready(m_ready), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic int nlanes(input logic [3:0] m);
        int n = 0;
        for (int g = 0; g < 4; g++) if (!m[g]) n++;
        return n;
    endfunction

    function automatic logic [31:0] squeeze(input logic [31:0] s, input logic [3:0] m);
        logic [31:0] r = '0;
        int k = 0;
        for (int g = 0; g < 4; g++) begin
            if (!m[g]) begin
                r[k*8 +: 8] = s[g*8 +: 8];
                k++;
            end
        end
        return r;
    endfunction

    task automatic emit(input logic [31:0] w, input int e);
        for (int b = 0; b < e; b++) exp_q.push_back(w[b*8 +: 8]);
    endtask

    task automatic build_expect(input logic [3:0] m, input bit rle, input int limit);
        int e = nlanes(m);
        int n = smp_q.size();
        logic [31:0] top = (e == 0) ? 32'h0 : (32'h1 << (8*e - 1));
        logic [31:0] cap = (e == 0) ? 32'h0 : top - 32'h1;
        int i = 0;
        int tot = 0;
        exp_q.delete();
        if (!rle) begin
            for (int j = 0; j < n && j < limit; j++) emit(squeeze(smp_q[j], m), e);
        end else begin
            while (i < n && tot < limit) begin
                logic [31:0] v = squeeze(smp_q[i], m) & ~top;
                logic [31:0] run = 0;
                tot++; i++;
                while (i < n && tot < limit && (squeeze(smp_q[i], m) & ~top) == v && run < cap) begin
                    run++; tot++; i++;
                end
                emit(v, e);
                if (run != 0) emit(run | top, e);
            end
        end
    endtask

    task automatic run_case(input logic [3:0] m, input bit rle, input logic [15:0] qm1,
                            input string tag_len, input string tag_byte);
        int idx = 0;
        int cyc = 0;
        int n = smp_q.size();
        bit prev_stall = 0;
        logic [7:0] prev_data = '0;
        bit quiet = 1;
        build_expect(m, rle, (int'(qm1) + 1) * 4);
        got_q.delete();
        @(negedge clk);
        arm = 1; cfg_grp_off = m; cfg_rle = rle; cfg_quads_m1 = qm1;
        s_valid = 0; s_last = 0;
        @(negedge clk);
        arm = 0;
        while ((idx < n || !done) && cyc < 20000) begin
            if (cyc != 0) @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m_ready = (lfsr[1:0] != 2'b00);
            if (idx < n) begin
                s_valid = 1; s_data = smp_q[idx]; s_last = (idx == n - 1);
            end else begin
                s_valid = 0; s_last = 0;
            end
            #1;
            if (prev_stall)
                chk(m_valid && m_data == prev_data, "R10", "held byte",
                    {m_valid, m_data}, {1'b1, prev_data});
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
            if (m_valid && m_ready) got_q.push_back(m_data);
            if (s_valid && s_ready) idx++;
        end
        s_valid = 0; s_last = 0;
        chk(done == 1'b1, "R9", "done after capture", done, 1);
        repeat (5) begin
            @(negedge clk); m_ready = 1; #1;
            if (m_valid) quiet = 0;
        end
        chk(quiet, "R8", "no bytes after completion", !quiet, 0);
        chk(got_q.size() == exp_q.size(), tag_len, "byte count", got_q.size(), exp_q.size());
        for (int b = 0; b < exp_q.size() && b < got_q.size(); b++)
            chk(got_q[b] == exp_q[b], tag_byte, "byte value", got_q[b], exp_q[b]);
    endtask

    task automatic build_mix(input logic [31:0] seed);
        logic [31:0] v = seed;
        smp_q.delete();
        for (int r = 0; r < 10; r++) begin
            v = v * 32'd1103515245 + 32'd12345;
            for (int k = 0; k < (r * 3) % 5 + 1; k++) smp_q.push_back(v);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: quiet before arming
        chk(!m_valid && !s_ready && !done, "R1", "idle outputs",
            {m_valid, s_ready, done}, 0);
        rst_n = 1;
        @(negedge clk); #1;
        chk(!m_valid && !s_ready && !done, "R1", "idle after reset release",
            {m_valid, s_ready, done}, 0);

        // Sweep every group mask in both modes (R2 R3 R4 R5 R6 R11)
        for (int rl = 0; rl < 2; rl++) begin
            for (int m = 0; m < 16; m++) begin
                build_mix(32'h1234_0000 + 32'(m * 77 + rl));
                if (m == 15)      run_case(4'(m), rl[0], 16'd15, "R11", "R11");
                else if (rl == 1) run_case(4'(m), 1'b1, 16'd15, "R6", "R5");
                else if (m == 0)  run_case(4'(m), 1'b0, 16'd15, "R3", "R4");
                else              run_case(4'(m), 1'b0, 16'd15, "R3", "R2");
            end
        end

        // R7: single-group run of 300 splits at 127 extra
        smp_q.delete();
        repeat (300) smp_q.push_back(32'hA1B2_C3C5);
        smp_q.push_back(32'h0000_0011);
        smp_q.push_back(32'h0000_0022);
        run_case(4'b1110, 1'b1, 16'd99, "R7", "R7");

        // R7: two groups hold the whole run in one pair
        smp_q.delete();
        repeat (300) smp_q.push_back(32'hFFEE_0102);
        run_case(4'b0011, 1'b1, 16'd99, "R7", "R6");

        // R8: budget of 8 cuts the second run short
        smp_q.delete();
        repeat (3) smp_q.push_back(32'h8080_8080);
        repeat (10) smp_q.push_back(32'h0102_0304);
        run_case(4'b0000, 1'b1, 16'd0 + 16'd1, "R8", "R8");

        // R8: value change on the sample that reaches the limit
        smp_q.delete();
        repeat (7) smp_q.push_back(32'h5555_5555);
        repeat (4) smp_q.push_back(32'h6666_6666);
        run_case(4'b0100, 1'b1, 16'd1, "R8", "R6");

        // R8: plain mode stops after four samples
        smp_q.delete();
        for (int k = 0; k < 10; k++) smp_q.push_back(32'hC0DE_0000 + 32'(k));
        run_case(4'b0000, 1'b0, 16'd0, "R8", "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule